// File: doc/BRIEF.md
# Audio Converter Timing Generator

This block produces every timing signal a stereo or mono sampling audio converter needs from one master clock. A synchronous binary counter runs freely, and fixed power-of-two taps of it become the conversion strobe (`hold`), the channel select (`lr_sel`) and the serial bit clock (`bclk`). A registered end-of-word pulse (`eow`) is decoded from the same taps, so it tells the data receiver when the last bit of a word is on the line.

In stereo use there is one conversion every 256 master clocks, and the channels alternate on each conversion. A 2-bit mode input can instead pin the channel select to the left or the right channel for mono use. In mono use the word pulse is then qualified by the divide-by-512 tap. Every output is a register driven from the master clock.

Top module: `audio_tgen`

## Requirements
- R1: `hold` has a period of 256 clocks. It is low for exactly HOLD_LOW clocks (default 2) at the start of each frame, where counter bits [7:0] < HOLD_LOW, and high for the rest of the frame.
- R2: In stereo mode (`mode` = 2'b00), `lr_sel` is a copy of counter bit 8. It is low for the first 256-clock frame after reset and toggles every 256 clocks, at the same edge where `hold` falls.
- R3: `bclk` is counter bit 3: a 50% duty clock with a period of 16 master clocks, low during the first 8 clocks after reset.
- R4: With `mode` = 2'b01, `lr_sel` is held high (left). With `mode` = 2'b10, `lr_sel` is held low (right).
- R5: `mode` = 2'b11 behaves exactly like stereo mode.
- R6: In stereo mode, `eow` is high for the 16 clocks of each frame in which counter bits [7:4] are all ones. That is once per 256 clocks, during the final bit period, and only while `hold` is high.
- R7: In either mono mode, `eow` also requires counter bit 8 to be high, so it occurs once per 512 clocks.
- R8: All outputs are registered, one clock behind the counter value they decode. While `rst` (synchronous, active high) is sampled high, the outputs read `hold`=1, `lr_sel`=0, `bclk`=0, `eow`=0, and the counter clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous reset, active high |
| mode | input | 2 | 00/11 stereo, 01 mono left, 10 mono right |
| hold | output | 1 | conversion strobe; a falling edge starts a conversion |
| lr_sel | output | 1 | channel select, high = left |
| bclk | output | 1 | serial bit clock, master/16 |
| eow | output | 1 | end-of-word pulse |

## Verification
The hardest case to reach is the mono word pulse. It depends on counter bit 8, so it is seen only on every other frame, and a mode change or a reset in the middle of a frame shifts its phase. The stimulus runs each mode for several 512-clock periods. It switches modes in the middle of a frame and applies a reset in the middle of a run. A cycle-exact reference counter in the bench predicts every output, and that counter restarts whenever the bench drives reset.

// File: rtl/audio_tgen.sv
module audio_tgen #(
  parameter int CNT_W    = 9,
  parameter int HOLD_LOW = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  output logic       hold,
  output logic       lr_sel,
  output logic       bclk,
  output logic       eow
);
  localparam int BCLK_TAP = 3;
  localparam int WORD_LO  = 4;
  localparam int WORD_HI  = 7;
  localparam int LR_TAP   = 8;

  logic [CNT_W-1:0] cnt;
  logic             stereo;
  logic             word_end;
  logic             lr_nxt;

  assign stereo   = (mode == 2'b00) || (mode == 2'b11);
  assign word_end = (&cnt[WORD_HI:WORD_LO]) && (stereo || cnt[LR_TAP]);
  assign lr_nxt   = stereo ? cnt[LR_TAP] : (mode == 2'b01);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      hold   <= 1'b1;
      lr_sel <= 1'b0;
      bclk   <= 1'b0;
      eow    <= 1'b0;
    end else begin
      cnt    <= cnt + 1'b1;
      hold   <= (cnt[WORD_HI:0] >= 8'(HOLD_LOW));
      lr_sel <= lr_nxt;
      bclk   <= cnt[BCLK_TAP];
      eow    <= word_end;
    end
  end

  assert_hold_fall_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> !bclk);

  assert_bclk_edge_phase_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(bclk) |-> (cnt[2:0] == 3'd1));

  assert_left_pinned_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> lr_sel);

  assert_right_pinned_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> !lr_sel);

  assert_eow_inside_hold_R6: assert property (@(posedge clk) disable iff (rst)
    eow |-> hold);

  assert_mono_eow_gated_R7: assert property (@(posedge clk) disable iff (rst)
    eow |-> ($past(mode) == 2'b00 || $past(mode) == 2'b11 || $past(cnt[LR_TAP])));
endmodule

// File: tb/tb_audio_tgen.sv
module tb_audio_tgen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HOLD_LOW   = 2;

  typedef struct packed {
    logic is_rst;
    logic hold;
    logic lr;
    logic bclk;
    logic eow;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       hold, lr_sel, bclk, eow;

  int   compared = 0;
  int   mismatched = 0;
  int   cycles = 0;
  bit   done = 1'b0;
  int   m = 0;
  exp_t q[$];

  audio_tgen #(.CNT_W(9), .HOLD_LOW(HOLD_LOW)) dut (
    .clk(clk), .rst(rst), .mode(mode),
    .hold(hold), .lr_sel(lr_sel), .bclk(bclk), .eow(eow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model(int n, logic [1:0] md);
    exp_t e;
    logic [8:0] c;
    logic st;
    c  = 9'(n);
    st = (md == 2'b00) || (md == 2'b11);
    e.is_rst = 1'b0;
    e.hold   = (c[7:0] >= 8'(HOLD_LOW));
    e.bclk   = c[3];
    e.lr     = st ? c[8] : (md == 2'b01);
    e.eow    = (&c[7:4]) && (st || c[8]);
    return e;
  endfunction

  always @(posedge clk) begin
    exp_t e;
    cycles++;
    if (rst) begin
      e = '{is_rst: 1'b1, hold: 1'b1, lr: 1'b0, bclk: 1'b0, eow: 1'b0};
      m = 0;
    end else begin
      e = model(m, mode);
      m = (m + 1) % 512;
    end
    q.push_back(e);
  end

  task automatic cmp(input logic act, input logic ex, input string req, input string name);
    compared++;
    if (act !== ex) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, name, act, ex, cycles);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      if (e.is_rst) begin
        cmp(hold,   e.hold, "R8", "reset hold");
        cmp(lr_sel, e.lr,   "R8", "reset lr_sel");
        cmp(bclk,   e.bclk, "R8", "reset bclk");
        cmp(eow,    e.eow,  "R8", "reset eow");
      end else begin
        cmp(hold, e.hold, "R1", "hold");
        cmp(bclk, e.bclk, "R3", "bclk");
        case (mode)
          2'b00:   begin cmp(lr_sel, e.lr, "R2", "lr_sel"); cmp(eow, e.eow, "R6", "eow"); end
          2'b11:   begin cmp(lr_sel, e.lr, "R5", "lr_sel"); cmp(eow, e.eow, "R5", "eow"); end
          default: begin cmp(lr_sel, e.lr, "R4", "lr_sel"); cmp(eow, e.eow, "R7", "eow"); end
        endcase
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    run(1200);
    mode = 2'b01;
    run(1100);
    mode = 2'b10;
    run(1100);
    mode = 2'b11;
    run(700);
    mode = 2'b00;
    run(333);
    rst = 1'b1;
    run(3);
    rst = 1'b0;
    mode = 2'b01;
    run(777);
    mode = 2'b00;
    run(600);
    run(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule